// File: doc/BRIEF.md
# SMBus Information ROM and Scratch Memory Slave

This block is a byte-wide memory target on a two-wire SMBus/I2C segment. It presents 256 byte locations behind one 8-bit offset. Offsets 00h to 7Fh hold a fixed information image that is built from a seed parameter when the design is elaborated. Software can never change that half. Offsets 80h to FFhh form a 128-byte scratch area. Writes to the scratch area are accepted only while the write-protect input is low.

The 7-bit target address is the fixed prefix 1010b followed by three strap inputs. Up to eight such targets can share one bus. The block supports Write Byte and Read Byte transfers. Both a write and a read begin by sending the offset. In a read, a repeated START and the read-direction address follow the offset, and then the block returns one data byte. The information image is split into seven sections, and each section ends in a checksum byte. After every reset a scanner walks the image once and reports, for each section, whether that section sums to zero.

The block drives the data line only as an open-drain pull-down enable. The clock and data lines are sampled through a synchronizer on the system clock.

FSM states are ST_IDLE, ST_ADDR, ST_ACK_ADDR, ST_OFFSET, ST_ACK_OFFSET, ST_WDATA, ST_ACK_WDATA, ST_RDATA, ST_MACK and ST_IGNORE. The transitions are:
- A START in any state goes to ST_ADDR. A STOP in any state goes to ST_IDLE.
- ST_ADDR goes to ST_ACK_ADDR when the address matches, and to ST_IGNORE otherwise.
- From ST_ACK_ADDR the block goes to ST_RDATA when the read bit is set, and to ST_OFFSET when it is clear.
- The write path runs ST_OFFSET, then ST_ACK_OFFSET, then ST_WDATA, then ST_ACK_WDATA, then ST_IGNORE.
- The read path runs ST_RDATA, then ST_MACK, then ST_IGNORE.
- Every step out of a byte or ACK state happens on an SCL falling edge, except the step out of ST_MACK, which happens on the SCL rising edge that samples the master's acknowledge.

Top module: `smbus_prom_slave`

## Requirements
- R1: The block acknowledges (pulls SDA low during the 9th clock) only an address byte whose upper seven bits equal 1010b followed by strap_i[2:0]; bit 0 of that byte is the direction, 1 = read. For any other address it leaves SDA released for the rest of that transfer, including the following bytes and the read data, until the next START.
- R2: A Write Byte (address with direction 0, offset, data) to offset 80h..FFh while wp_i is low stores the data; a later Read Byte at that offset returns it. All three bytes are acknowledged.
- R3: While wp_i is high, a Write Byte to offset 80h..FFh is acknowledged on all three bytes but leaves the stored byte unchanged.
- R4: A Write Byte to offset 00h..7Fh is acknowledged on all three bytes and has no effect on the stored contents.
- R5: A Read Byte (address with direction 0, offset, repeated START, address with direction 1) returns the byte at the offset, MSB first. After that single byte the block releases SDA whether the master acknowledges or not, so a further byte clocked in by the master reads FFh.
- R6: Offsets 01h and 02h hold the 16-bit image size, MSB first: 00h then 80h.
- R7: The image is split into sections that end at offsets 0Dh, 15h, 24h, 31h, 37h, 6Fh and 7Fh. Within each section the bytes, including the closing checksum byte, sum to 00h modulo 256.
- R8: Within 130 clock cycles after reset is released, scan_done_o rises and then stays high. sect_ok_o bit k then reports that section k (counted from offset 00h upward) sums to zero; with a consistent image all seven bits are 1.
- R9: During and right after reset, sda_oe_o is 0 and scan_done_o is 0, and every scratch byte reads 00h.
- R10: sda_oe_o changes only while SCL is low; it stays constant across any stretch in which SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCL and SDA are oversampled on it |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Low three bits of the target address |
| wp_i | input | 1 | High blocks writes to the scratch half |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| sect_ok_o | output | 7 | Per-section checksum result, bit k = section k |
| scan_done_o | output | 1 | Checksum scan finished since reset |

## Verification
The assertions assume that the bus is driven legally:
- SDA changes only while SCL is low, except at START and STOP.
- The master never issues a START or STOP while the block is pulling SDA low.
- Each SCL phase lasts several system clocks, so the synchronizer sees every edge.

The bench keeps within these limits. It drives the lines in quarter-bit steps of ten clock cycles. It changes master data only a full quarter after a falling edge, and it places START and STOP only in states where the block has released SDA. The bench also watches SDA against SCL itself. This confirms the no-change-while-high property from outside the RTL.

// File: rtl/prom_pkg.sv
package prom_pkg;

    localparam int unsigned HALF_BYTES = 128;
    localparam int unsigned NUM_SECT   = 7;
    localparam int unsigned STRAP_W    = 3;
    localparam logic [3:0]  ADDR_PREFIX = 4'b1010;

    // last offset of each image section, ascending
    localparam int unsigned SECT_LAST [NUM_SECT] = '{13, 21, 36, 49, 55, 111, 127};

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_OFFSET,
        ST_ACK_OFFSET,
        ST_WDATA,
        ST_ACK_WDATA,
        ST_RDATA,
        ST_MACK,
        ST_IGNORE
    } bus_state_e;

    function automatic logic is_sect_last(input int unsigned pos);
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < NUM_SECT; k++) begin
            if (SECT_LAST[k] == pos) hit = 1'b1;
        end
        return hit;
    endfunction

    // image: size field 0080h at 01h/02h, seeded filler, closing checksum per section
    function automatic logic [HALF_BYTES*8-1:0] build_image(input logic [7:0] seed);
        logic [HALF_BYTES*8-1:0] img;
        logic [7:0] run;
        logic [7:0] b;
        img = '0;
        run = 8'h00;
        for (int i = 0; i < HALF_BYTES; i++) begin
            if (i == 1)                  b = 8'h00;
            else if (i == 2)             b = 8'h80;
            else if (is_sect_last(i))    b = 8'h00 - run;
            else                         b = 8'(i * 29) + seed;
            img[i*8 +: 8] = b;
            if (is_sect_last(i)) run = 8'h00;
            else                 run = run + b;
        end
        return img;
    endfunction

endpackage

// File: rtl/prom_bus_sync.sv
module prom_bus_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_i;
                    sda_sh <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[STAGES-2:0], scl_i};
                    sda_sh <= {sda_sh[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_sh[STAGES-1];
            sda_d <= sda_sh[STAGES-1];
        end
    end

    always_comb begin
        scl_q    = scl_sh[STAGES-1];
        sda_q    = sda_sh[STAGES-1];
        scl_rise = scl_q & ~scl_d;
        scl_fall = ~scl_q & scl_d;
        start_ev = scl_q & scl_d & sda_d & ~sda_q;
        stop_ev  = scl_q & scl_d & ~sda_d & sda_q;
    end

endmodule

// File: rtl/prom_store.sv
module prom_store
    import prom_pkg::*;
#(
    parameter logic [7:0] SEED = 8'h3B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_req_i,
    input  logic       wp_i,
    input  logic [7:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o
);
    localparam int unsigned AW = $clog2(HALF_BYTES);
    localparam logic [HALF_BYTES*8-1:0] IMG = build_image(SEED);

    logic [7:0] scratch [HALF_BYTES];
    logic       wr_ok;

    always_comb wr_ok = wr_req_i && addr_i[AW] && !wp_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HALF_BYTES; i++) scratch[i] <= 8'h00;
        end else if (wr_ok) begin
            scratch[addr_i[AW-1:0]] <= wdata_i;
        end
    end

    always_comb begin
        if (addr_i[AW]) rdata_o = scratch[addr_i[AW-1:0]];
        else            rdata_o = IMG[{addr_i[AW-1:0], 3'b000} +: 8];
    end

    assert_scratch_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && !wp_i && addr_i[AW]) |=>
        (scratch[$past(addr_i[AW-1:0])] == $past(wdata_i)));

    assert_wp_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && wp_i && addr_i[AW]) |=>
        (scratch[$past(addr_i[AW-1:0])] == $past(scratch[addr_i[AW-1:0]])));

endmodule

// File: rtl/prom_csum_scan.sv
module prom_csum_scan
    import prom_pkg::*;
#(
    parameter logic [7:0] SEED = 8'h3B
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [NUM_SECT-1:0] sect_ok_o,
    output logic                done_o
);
    localparam int unsigned IW = $clog2(HALF_BYTES);
    localparam int unsigned SW = $clog2(NUM_SECT);
    localparam logic [HALF_BYTES*8-1:0] IMG = build_image(SEED);

    typedef enum logic {SC_RUN, SC_DONE} scan_e;

    scan_e              st;
    logic [IW-1:0]      idx;
    logic [SW-1:0]      sect;
    logic [7:0]         acc;
    logic [NUM_SECT-1:0] ok_q;
    logic [7:0]         cur;
    logic [7:0]         sum;

    always_comb begin
        cur = IMG[{idx, 3'b000} +: 8];
        sum = acc + cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= SC_RUN;
            idx  <= '0;
            sect <= '0;
            acc  <= 8'h00;
            ok_q <= '0;
        end else begin
            unique case (st)
                SC_RUN: begin
                    if (is_sect_last(int'(idx))) begin
                        ok_q[sect] <= (sum == 8'h00);
                        acc        <= 8'h00;
                        sect       <= sect + 1'b1;
                    end else begin
                        acc <= sum;
                    end
                    if (idx == IW'(HALF_BYTES - 1)) st <= SC_DONE;
                    else                            idx <= idx + 1'b1;
                end
                SC_DONE: st <= SC_DONE;
                default: st <= SC_DONE;
            endcase
        end
    end

    always_comb begin
        done_o    = (st == SC_DONE);
        sect_ok_o = ok_q;
    end

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (idx == IW'(HALF_BYTES - 1)));

endmodule

// File: rtl/smbus_prom_slave.sv
module smbus_prom_slave #(
    parameter logic [7:0]  ROM_SEED    = 8'h3B,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              scl_i,
    input  logic                              sda_i,
    input  logic [prom_pkg::STRAP_W-1:0]      strap_i,
    input  logic                              wp_i,
    output logic                              sda_oe_o,
    output logic [prom_pkg::NUM_SECT-1:0]     sect_ok_o,
    output logic                              scan_done_o
);
    import prom_pkg::*;

    logic scl_q, sda_q, ev_rise, ev_fall, ev_start, ev_stop;

    bus_state_e state;
    logic [2:0] cnt;
    logic       byte_done;
    logic [7:0] sh;
    logic [7:0] offset;
    logic [7:0] tx;
    logic       rw;
    logic [7:0] rdata;
    logic       wr_req;
    logic       addr_hit;

    prom_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_q    (scl_q),
        .sda_q    (sda_q),
        .scl_rise (ev_rise),
        .scl_fall (ev_fall),
        .start_ev (ev_start),
        .stop_ev  (ev_stop)
    );

    prom_store #(.SEED(ROM_SEED)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req_i (wr_req),
        .wp_i     (wp_i),
        .addr_i   (offset),
        .wdata_i  (sh),
        .rdata_o  (rdata)
    );

    prom_csum_scan #(.SEED(ROM_SEED)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .sect_ok_o (sect_ok_o),
        .done_o    (scan_done_o)
    );

    always_comb addr_hit = (sh[7:1] == {ADDR_PREFIX, strap_i});

    // state register and byte datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= 3'd0;
            byte_done <= 1'b0;
            sh        <= 8'h00;
            offset    <= 8'h00;
            tx        <= 8'h00;
            rw        <= 1'b0;
        end else if (ev_start) begin
            state     <= ST_ADDR;
            cnt       <= 3'd0;
            byte_done <= 1'b0;
            sh        <= 8'h00;
        end else if (ev_stop) begin
            state     <= ST_IDLE;
            byte_done <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: begin
                    byte_done <= 1'b0;
                end
                ST_ADDR, ST_OFFSET, ST_WDATA: begin
                    if (ev_rise) begin
                        sh  <= {sh[6:0], sda_q};
                        cnt <= cnt + 1'b1;
                        if (cnt == 3'd7) byte_done <= 1'b1;
                    end else if (ev_fall && byte_done) begin
                        byte_done <= 1'b0;
                        if (state == ST_ADDR) begin
                            if (addr_hit) begin
                                rw    <= sh[0];
                                state <= ST_ACK_ADDR;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end else if (state == ST_OFFSET) begin
                            offset <= sh;
                            state  <= ST_ACK_OFFSET;
                        end else begin
                            state  <= ST_ACK_WDATA;
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (ev_fall) begin
                        cnt <= 3'd0;
                        if (rw) begin
                            tx    <= rdata;
                            state <= ST_RDATA;
                        end else begin
                            state <= ST_OFFSET;
                        end
                    end
                end
                ST_ACK_OFFSET: begin
                    if (ev_fall) begin
                        cnt   <= 3'd0;
                        state <= ST_WDATA;
                    end
                end
                ST_ACK_WDATA: begin
                    if (ev_fall) state <= ST_IGNORE;
                end
                ST_RDATA: begin
                    if (ev_rise) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == 3'd7) byte_done <= 1'b1;
                    end else if (ev_fall) begin
                        if (byte_done) begin
                            byte_done <= 1'b0;
                            state     <= ST_MACK;
                        end else begin
                            tx <= {tx[6:0], 1'b0};
                        end
                    end
                end
                ST_MACK: begin
                    if (ev_rise) state <= ST_IGNORE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe_o = 1'b0;
        wr_req   = 1'b0;
        unique case (state)
            ST_ACK_ADDR, ST_ACK_OFFSET, ST_ACK_WDATA: sda_oe_o = 1'b1;
            ST_RDATA:  sda_oe_o = ~tx[7];
            ST_WDATA:  wr_req   = ev_fall && byte_done && !ev_start && !ev_stop;
            default:   sda_oe_o = 1'b0;
        endcase
    end

    assert_sda_quiet_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_q && $past(scl_q)) |-> $stable(sda_oe_o));

    assert_foreign_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && ev_fall && byte_done && !addr_hit) |=>
        (state == ST_IGNORE && !sda_oe_o));

    assert_read_single_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MACK && ev_rise) |=> (state == ST_IGNORE && !sda_oe_o));

endmodule

// File: tb/smbus_prom_slave_test.sv
module smbus_prom_slave_test;
    import prom_pkg::*;

    localparam int Q = 10;
    localparam logic [6:0] DEV_A = {ADDR_PREFIX, 3'b010};
    localparam logic [6:0] DEV_B = {ADDR_PREFIX, 3'b101};

    typedef struct packed {
        logic       wr;
        logic       wp;
        logic [7:0] off;
        logic [7:0] data;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'h80, 8'hA5, 4'd2},   // R2 store
        '{1'b0, 1'b0, 8'h80, 8'hA5, 4'd2},   // R2 read back
        '{1'b1, 1'b0, 8'hFF, 8'h3C, 4'd2},   // R2 top byte
        '{1'b0, 1'b0, 8'hFF, 8'h3C, 4'd2},
        '{1'b1, 1'b1, 8'h80, 8'h11, 4'd3},   // R3 protected
        '{1'b0, 1'b1, 8'h80, 8'hA5, 4'd3},
        '{1'b0, 1'b0, 8'h01, 8'h00, 4'd6},   // R6 size MSB
        '{1'b0, 1'b0, 8'h02, 8'h80, 4'd6},   // R6 size LSB
        '{1'b1, 1'b0, 8'h02, 8'h55, 4'd4},   // R4 image write
        '{1'b0, 1'b0, 8'h02, 8'h80, 4'd4},
        '{1'b1, 1'b1, 8'hC3, 8'h7E, 4'd3},   // R3 protected, fresh byte
        '{1'b0, 1'b0, 8'hC3, 8'h00, 4'd9}    // R9 reset value kept
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic wp = 1'b0;
    logic [STRAP_W-1:0] strap = 3'b010;
    logic sda_oe;
    logic done;
    logic [NUM_SECT-1:0] ok;
    wire  sda_bus = ~(m_sda_low | sda_oe);

    int nchk = 0;
    int nfail = 0;
    bit ended = 1'b0;
    int glitches = 0;
    logic scl_prev = 1'b1;
    logic oe_prev = 1'b0;

    always #10 clk = ~clk;

    smbus_prom_slave uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_bus),
        .strap_i     (strap),
        .wp_i        (wp),
        .sda_oe_o    (sda_oe),
        .sect_ok_o   (ok),
        .scan_done_o (done)
    );

    // R10 observer: block output must not move while SCL is high
    always @(posedge clk) begin
        if (rst_n && m_scl && scl_prev && (sda_oe !== oe_prev)) glitches++;
        scl_prev = m_scl;
        oe_prev  = sda_oe;
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; qwait();
        m_scl = 1'b1;     qwait();
        m_sda_low = 1'b1; qwait();
        m_scl = 1'b0;     qwait();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; qwait();
        m_scl = 1'b1;     qwait();
        m_sda_low = 1'b0; qwait();
    endtask

    task automatic send_bit(input logic b);
        m_sda_low = ~b; qwait();
        m_scl = 1'b1;   qwait(); qwait();
        m_scl = 1'b0;   qwait();
    endtask

    task automatic recv_bit(output logic b);
        m_sda_low = 1'b0; qwait();
        m_scl = 1'b1;     qwait();
        b = sda_bus;      qwait();
        m_scl = 1'b0;     qwait();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic nack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(nack);
    endtask

    task automatic recv_byte(input logic master_nack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        send_bit(master_nack);
    endtask

    task automatic write_tx(input logic [6:0] dev, input logic [7:0] off, input logic [7:0] d,
                            output logic [2:0] nacks);
        bus_start();
        send_byte({dev, 1'b0}, nacks[2]);
        send_byte(off, nacks[1]);
        send_byte(d, nacks[0]);
        bus_stop();
    endtask

    task automatic read_tx(input logic [6:0] dev, input logic [7:0] off,
                           output logic [7:0] d, output logic [2:0] nacks);
        bus_start();
        send_byte({dev, 1'b0}, nacks[2]);
        send_byte(off, nacks[1]);
        bus_start();
        send_byte({dev, 1'b1}, nacks[0]);
        recv_byte(1'b1, d);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog R9 actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [2:0] nk;
        logic [7:0] rd;
        logic [7:0] rd2;
        logic [7:0] sum;

        repeat (5) @(negedge clk);
        check("R9 sda_oe in reset", sda_oe, 1'b0);
        check("R9 scan_done in reset", done, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 sda_oe after reset", sda_oe, 1'b0);
        check("R9 scan_done after reset", done, 1'b0);
        repeat (130) @(negedge clk);
        check("R8 scan_done", done, 1'b1);
        check("R8 all sections ok", ok, 7'h7F);

        // table walk
        for (int i = 0; i < NV; i++) begin
            wp = VECS[i].wp;
            if (VECS[i].wr) begin
                write_tx(DEV_A, VECS[i].off, VECS[i].data, nk);
                check($sformatf("R%0d write acks off=%0h", VECS[i].req, VECS[i].off), nk, 3'b000);
            end else begin
                read_tx(DEV_A, VECS[i].off, rd, nk);
                check($sformatf("R%0d read acks off=%0h", VECS[i].req, VECS[i].off), nk, 3'b000);
                check($sformatf("R%0d read data off=%0h", VECS[i].req, VECS[i].off), rd, VECS[i].data);
            end
        end
        wp = 1'b0;

        // R1: strap change, old address is foreign now
        strap = 3'b101;
        write_tx(DEV_A, 8'h80, 8'h00, nk);
        check("R1 foreign write nacked", nk, 3'b111);
        read_tx(DEV_A, 8'h80, rd, nk);
        check("R1 foreign read nacked", nk, 3'b111);
        check("R1 foreign read data released", rd, 8'hFF);
        read_tx(DEV_B, 8'h80, rd, nk);
        check("R1 new strap acked", nk, 3'b000);
        check("R1 foreign write had no effect", rd, 8'hA5);
        check("R1 sda released after stop", sda_oe, 1'b0);

        // R5: master acknowledges, block still ends after one byte
        bus_start();
        send_byte({DEV_B, 1'b0}, nk[2]);
        send_byte(8'hFF, nk[1]);
        bus_start();
        send_byte({DEV_B, 1'b1}, nk[0]);
        recv_byte(1'b0, rd);
        recv_byte(1'b1, rd2);
        bus_stop();
        check("R5 acks", nk, 3'b000);
        check("R5 first byte", rd, 8'h3C);
        check("R5 second byte released", rd2, 8'hFF);

        // R7: section sums, first and last section
        sum = 8'h00;
        for (int a = 8'h00; a <= 8'h0D; a++) begin
            read_tx(DEV_B, 8'(a), rd, nk);
            sum = sum + rd;
        end
        check("R7 section 0 sum", sum, 8'h00);
        sum = 8'h00;
        for (int a = 8'h70; a <= 8'h7F; a++) begin
            read_tx(DEV_B, 8'(a), rd, nk);
            sum = sum + rd;
        end
        check("R7 section 6 sum", sum, 8'h00);

        check("R10 no SDA change while SCL high", glitches, 0);
        check("R8 scan_done still high", done, 1'b1);
        finish_run();
    end

endmodule